// File: doc/BRIEF.md
# Scaled-Index Shift-and-Add Unit

This execution unit forms `base + (index << (sm + 1))` for a 64-bit integer pipeline, the arithmetic behind scaled array indexing and address offsets. It decodes one 32-bit instruction word into its fields and selects one of three variants. The full variant shifts the whole 64-bit index operand. The signed-word variant first sign-extends the low 32 bits of the index. The unsigned-word variant first zero-extends them. The sum wraps modulo 2^64. Any bits shifted or carried above bit 63 are lost, and no carry or overflow indication exists.

The instruction, the base value and the index value arrive together on a valid/ready input stream. A result record leaves on a valid/ready output stream. The record holds the sum, the destination register index, three condition flags and an illegal-encoding indication. The parameter `OUT_REG` selects one of two builds. With `OUT_REG = 1` (the default), the output sits in a one-entry register and appears one cycle after acceptance. While a result is held and `out_ready` is low, `in_ready` is low, and the held record stays unchanged until it is taken. With `OUT_REG = 0`, the unit is purely combinational: `out_valid` follows `in_valid` and `in_ready` follows `out_ready`.

The flags are a signed comparison of the result against zero. They are produced only when the instruction's record bit is set.

Top module: `sas_unit`

## Requirements
- R1: The shift amount is the 2-bit field at `in_insn[10:9]` plus one, so the index is scaled by 2, 4, 8 or 16 for field values 0 to 3.
- R2: The full variant (extended opcode 1) gives `out_result = (index << shift) + base` modulo 2^64, using all 64 index bits.
- R3: The signed-word variant (extended opcode 2) sign-extends `in_index[31:0]` to 64 bits before the shift, and `in_index[63:32]` has no effect.
- R4: The unsigned-word variant (extended opcode 3) zero-extends `in_index[31:0]` before the shift, and `in_index[63:32]` has no effect.
- R5: The primary opcode is `in_insn[31:26]` and must equal `OPC_MAJOR` (default 22). The extended opcode is `in_insn[8:1]`. `out_dest` equals `in_insn[25:21]`.
- R6: When the record bit `in_insn[0]` is 1 on a legal instruction, `out_flags` is {less-than, greater-than, equal} in bits [2], [1] and [0], from a signed comparison of the result with zero. Otherwise `out_flags` is 3'b000.
- R7: When the opcodes match none of the three encodings, `out_illegal` is 1, and `out_result` and `out_flags` are zero. For a legal instruction `out_illegal` is 0.
- R8: With `OUT_REG = 1`, an accepted input appears on the output one cycle later. While `out_valid` is high and `out_ready` is low, the output record stays stable and `in_ready` is low. Once `out_ready` rises, the held record is consumed and a waiting input is accepted on the same edge.
- R9: During and right after reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input operation present |
| in_ready | output | 1 | Unit can accept an operation |
| in_insn | input | 32 | Instruction word |
| in_base | input | 64 | Base operand value |
| in_index | input | 64 | Index operand value |
| out_valid | output | 1 | Result record present |
| out_ready | input | 1 | Downstream takes the record |
| out_result | output | 64 | Scaled-index sum |
| out_dest | output | 5 | Destination register index |
| out_flags | output | 3 | {lt, gt, eq} condition flags |
| out_illegal | output | 1 | Opcode matched no variant |

## Verification
Most internal faults show up in the record of the very next output, one cycle after the faulty input is accepted.
- A wrong variant decode shows as a wrong upper half of the result, but only when the index has a nonzero upper half or a negative low word. For that reason those operand patterns are swept across every shift value.
- An off-by-one shift shows as a result off by a factor of two.
- A flag fault shows only on records whose record bit is set.
- A fault in the output register shows as a record that changes or vanishes while back-pressure is applied, or as `in_ready` staying high when it should be low.

// File: rtl/sas_pkg.sv
package sas_pkg;
  localparam int XLEN   = 64;
  localparam int WORD   = XLEN / 2;
  localparam int IW     = 32;
  localparam int REGW   = 5;
  localparam int SMW    = 2;
  localparam int SHW    = SMW + 1;
  localparam int FLAGW  = 3;
  localparam int MAXSH  = (1 << SMW);

  typedef enum logic [1:0] {
    VAR_FULL  = 2'd0,
    VAR_SWORD = 2'd1,
    VAR_UWORD = 2'd2,
    VAR_NONE  = 2'd3
  } variant_e;

  typedef struct packed {
    logic [XLEN-1:0]  result;
    logic [REGW-1:0]  dest;
    logic [FLAGW-1:0] flags;
    logic             illegal;
  } rec_t;
endpackage

// File: rtl/sas_decode.sv
module sas_decode
  import sas_pkg::*;
#(
  parameter logic [5:0] OPC_MAJOR = 6'd22,
  parameter logic [7:0] XO_FULL   = 8'd1,
  parameter logic [7:0] XO_SWORD  = 8'd2,
  parameter logic [7:0] XO_UWORD  = 8'd3
) (
  input  logic [IW-1:0]   insn,
  output variant_e        variant,
  output logic [REGW-1:0] dest,
  output logic [SMW-1:0]  sm,
  output logic            rc
);
  // LSB-0 positions of the MSB-first format fields
  localparam int PO_LO = IW - 6;
  localparam int RT_LO = PO_LO - REGW;
  localparam int SM_LO = IW - 23;
  localparam int XO_LO = 1;

  logic [5:0] po;
  logic [7:0] xo;
  logic       unused_src;

  assign po         = insn[IW-1:PO_LO];
  assign dest       = insn[PO_LO-1:RT_LO];
  assign sm         = insn[SM_LO+SMW-1:SM_LO];
  assign xo         = insn[XO_LO+7:XO_LO];
  assign rc         = insn[0];
  assign unused_src = ^insn[RT_LO-1:SM_LO+SMW];

  always_comb begin
    variant = VAR_NONE;
    if (po == OPC_MAJOR) begin
      if (xo == XO_FULL)       variant = VAR_FULL;
      else if (xo == XO_SWORD) variant = VAR_SWORD;
      else if (xo == XO_UWORD) variant = VAR_UWORD;
    end
  end
endmodule

// File: rtl/sas_datapath.sv
module sas_datapath
  import sas_pkg::*;
(
  input  variant_e         variant,
  input  logic [SMW-1:0]   sm,
  input  logic             rc,
  input  logic [XLEN-1:0]  base,
  input  logic [XLEN-1:0]  index,
  output logic [XLEN-1:0]  result,
  output logic [FLAGW-1:0] flags,
  output logic             illegal
);
  logic [XLEN-1:0] narrowed;
  logic [SHW-1:0]  shamt;
  logic [XLEN-1:0] sum;
  logic            lt, eq;

  always_comb begin
    case (variant)
      VAR_SWORD: narrowed = {{(XLEN-WORD){index[WORD-1]}}, index[WORD-1:0]};
      VAR_UWORD: narrowed = {{(XLEN-WORD){1'b0}}, index[WORD-1:0]};
      default:   narrowed = index;
    endcase
  end

  assign shamt   = SHW'(sm) + SHW'(1);
  assign sum     = (narrowed << shamt) + base;
  assign illegal = (variant == VAR_NONE);
  assign result  = illegal ? '0 : sum;
  assign lt      = result[XLEN-1];
  assign eq      = (result == '0);
  assign flags   = (rc && !illegal) ? {lt, !lt && !eq, eq} : '0;

  logic [XLEN-1:0] diff;
  logic [XLEN-1:0] low_mask;
  assign diff     = result - base;
  assign low_mask = (XLEN'(1) << shamt) - XLEN'(1);

  always_comb begin
    if (!illegal)
      p_scale_align_r1: assert ((diff & low_mask) == '0);
    if (variant == VAR_UWORD)
      p_uw_range_r4: assert ((diff >> (WORD + MAXSH)) == '0);
    if (variant == VAR_SWORD)
      p_sw_sign_r3: assert (diff[XLEN-1:WORD+MAXSH] ==
                            {(XLEN-WORD-MAXSH){index[WORD-1]}});
    if (rc && !illegal)
      p_flag_onehot_r6: assert ($onehot(flags));
    else
      p_flag_quiet_r6: assert (flags == '0);
    if (illegal)
      p_illegal_zero_r7: assert (result == '0);
  end
endmodule

// File: rtl/sas_outstage.sv
module sas_outstage
  import sas_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  input  rec_t in_rec,
  output logic out_valid,
  input  logic out_ready,
  output rec_t out_rec
);
  generate
    if (OUT_REG) begin : g_reg
      logic full;
      rec_t held;

      always_ff @(posedge clk) begin
        if (!rst_n) full <= 1'b0;
        else if (in_ready) full <= in_valid;
      end

      always_ff @(posedge clk) begin
        if (in_valid && in_ready) held <= in_rec;
      end

      assign in_ready  = !full || out_ready;
      assign out_valid = full;
      assign out_rec   = held;

      p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_rec)));
      p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);
    end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign in_ready   = out_ready;
      assign out_valid  = in_valid;
      assign out_rec    = in_rec;
    end
  endgenerate
endmodule

// File: rtl/sas_unit.sv
module sas_unit
  import sas_pkg::*;
#(
  parameter bit         OUT_REG   = 1'b1,
  parameter logic [5:0] OPC_MAJOR = 6'd22,
  parameter logic [7:0] XO_FULL   = 8'd1,
  parameter logic [7:0] XO_SWORD  = 8'd2,
  parameter logic [7:0] XO_UWORD  = 8'd3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IW-1:0]    in_insn,
  input  logic [XLEN-1:0]  in_base,
  input  logic [XLEN-1:0]  in_index,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [XLEN-1:0]  out_result,
  output logic [REGW-1:0]  out_dest,
  output logic [FLAGW-1:0] out_flags,
  output logic             out_illegal
);
  variant_e        variant;
  logic [REGW-1:0] dest;
  logic [SMW-1:0]  sm;
  logic            rc;
  rec_t            rec_in, rec_out;

  sas_decode #(
    .OPC_MAJOR(OPC_MAJOR), .XO_FULL(XO_FULL),
    .XO_SWORD(XO_SWORD), .XO_UWORD(XO_UWORD)
  ) u_decode (
    .insn(in_insn), .variant(variant), .dest(dest), .sm(sm), .rc(rc)
  );

  sas_datapath u_dp (
    .variant(variant), .sm(sm), .rc(rc),
    .base(in_base), .index(in_index),
    .result(rec_in.result), .flags(rec_in.flags), .illegal(rec_in.illegal)
  );

  assign rec_in.dest = dest;

  sas_outstage #(.OUT_REG(OUT_REG)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_rec(rec_in),
    .out_valid(out_valid), .out_ready(out_ready), .out_rec(rec_out)
  );

  assign out_result  = rec_out.result;
  assign out_dest    = rec_out.dest;
  assign out_flags   = rec_out.flags;
  assign out_illegal = rec_out.illegal;

  p_reset_r9: assert property (@(posedge clk) !rst_n |=> (!out_valid && in_ready));
endmodule

// File: tb/sim_sas_unit.sv
module sim_sas_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_insn = '0;
  logic [63:0] in_base = '0;
  logic [63:0] in_index = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_result;
  logic [4:0]  out_dest;
  logic [2:0]  out_flags;
  logic        out_illegal;

  int nvec = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sas_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_insn(in_insn), .in_base(in_base), .in_index(in_index),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_dest(out_dest), .out_flags(out_flags), .out_illegal(out_illegal)
  );

  localparam int NV = 8;
  localparam logic [7:0]  T_XO [NV] = '{8'd1, 8'd2, 8'd3, 8'd1, 8'd2, 8'd3, 8'd2, 8'd9};
  localparam logic        T_RC [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1};
  localparam logic [63:0] T_BASE [NV] = '{
    64'h0000_1000_0000_0000, 64'h0000_0000_0000_0100, 64'hFFFF_FFFF_FFFF_FF00,
    64'hFFFF_FFFF_FFFF_FFF0, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF,
    64'h0000_0000_0000_0000, 64'h0000_0000_0000_0042};
  localparam logic [63:0] T_IDX [NV] = '{
    64'hC000_0000_0000_0003, 64'h1234_5678_FFFF_FFFE, 64'hDEAD_BEEF_8000_0001,
    64'h8000_0000_0000_0001, 64'hAAAA_AAAA_7FFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF,
    64'h0000_0001_8000_0000, 64'h0000_0000_0000_0007};

  function automatic logic [31:0] mk(input logic [5:0] po, input logic [7:0] xo,
                                     input logic [1:0] sm, input logic [4:0] rt,
                                     input logic rc);
    return {po, rt, 5'd3, 5'd4, sm, xo, rc};
  endfunction

  function automatic logic [72:0] model(input logic [31:0] insn,
                                        input logic [63:0] b, input logic [63:0] x);
    logic [63:0] n, r;
    logic [2:0]  f;
    logic        ill;
    ill = 1'b0;
    n = x;
    if (insn[31:26] != 6'd22) ill = 1'b1;
    else if (insn[8:1] == 8'd2) n = {{32{x[31]}}, x[31:0]};
    else if (insn[8:1] == 8'd3) n = {32'd0, x[31:0]};
    else if (insn[8:1] != 8'd1) ill = 1'b1;
    r = ill ? 64'd0 : (n << (32'(insn[10:9]) + 1)) + b;
    f = 3'b000;
    if (insn[0] && !ill) begin
      if (r[63]) f = 3'b100;
      else if (r == 0) f = 3'b001;
      else f = 3'b010;
    end
    return {r, insn[25:21], f, ill};
  endfunction

  task automatic check(input string tag, input logic [73:0] act, input logic [73:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input string tag, input logic [31:0] insn,
                       input logic [63:0] b, input logic [63:0] x);
    @(negedge clk);
    in_valid = 1'b1; in_insn = insn; in_base = b; in_index = x;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(tag, {out_valid, out_result, out_dest, out_flags, out_illegal},
          {1'b1, model(insn, b, x)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset", {72'd0, out_valid, in_ready}, {72'd0, 1'b0, 1'b1});
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 after reset", {72'd0, out_valid, in_ready}, {72'd0, 1'b0, 1'b1});

    // table walk across every sm value
    for (int i = 0; i < NV; i++) begin
      for (int s = 0; s < 4; s++) begin
        string tag;
        tag = (T_XO[i] == 8'd1) ? "R2 full" : (T_XO[i] == 8'd2) ? "R3 sword" :
              (T_XO[i] == 8'd3) ? "R4 uword" : "R7 illegal";
        apply(tag, mk(6'd22, T_XO[i], 2'(s), 5'(i + s), T_RC[i]), T_BASE[i], T_IDX[i]);
      end
    end

    // R1 scale factors 2,4,8,16
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      in_valid = 1'b1; in_insn = mk(6'd22, 8'd1, 2'(s), 5'd1, 1'b0);
      in_base = 64'd0; in_index = 64'd1;
      @(posedge clk); @(negedge clk); in_valid = 1'b0;
      check("R1 scale", {10'd0, out_result}, {10'd0, 64'd2 << s});
    end

    // R3/R4 literal expectations, upper half of index ignored
    apply("R4 upper ignored", mk(6'd22, 8'd3, 2'd0, 5'd2, 1'b0), 64'd5, 64'hFFFF_FFFF_8000_0000);
    check("R4 literal", {10'd0, out_result}, {10'd0, 64'h0000_0001_0000_0005});
    apply("R3 negative word", mk(6'd22, 8'd2, 2'd0, 5'd2, 1'b1), 64'd5, 64'h0000_0000_8000_0000);
    check("R3 literal", {10'd0, out_result}, {10'd0, 64'hFFFF_FFFF_0000_0005});
    check("R6 negative lt", {71'd0, out_flags}, {71'd0, 3'b100});

    // R2 wrap to zero, R6 equal flag
    apply("R2 wrap", mk(6'd22, 8'd1, 2'd3, 5'd7, 1'b1), 64'hFFFF_FFFF_FFFF_FFF0, 64'h8000_0000_0000_0001);
    check("R6 eq", {71'd0, out_flags}, {71'd0, 3'b001});
    check("R2 wrap literal", {10'd0, out_result}, {10'd0, 64'd0});

    // R6 no record gives no flags
    apply("R6 no record", mk(6'd22, 8'd2, 2'd1, 5'd8, 1'b0), 64'd0, 64'h0000_0000_FFFF_FFFF);
    check("R6 flags off", {71'd0, out_flags}, {71'd0, 3'b000});

    // R5 destination field and wrong major opcode
    apply("R5 dest", mk(6'd22, 8'd3, 2'd2, 5'd19, 1'b1), 64'd1, 64'd1);
    check("R5 dest literal", {69'd0, out_dest}, {69'd0, 5'd19});
    apply("R7 bad major", mk(6'd23, 8'd1, 2'd0, 5'd4, 1'b1), 64'd9, 64'd9);
    check("R7 literal", {9'd0, out_illegal, out_result}, {9'd0, 1'b1, 64'd0});

    // R8 back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_insn = mk(6'd22, 8'd1, 2'd0, 5'd10, 1'b0);
    in_base = 64'd100; in_index = 64'd1;
    @(posedge clk); @(negedge clk);
    check("R8 first held", {8'd0, out_valid, in_ready, out_result}, {8'd0, 1'b1, 1'b0, 64'd102});
    in_insn = mk(6'd22, 8'd1, 2'd1, 5'd11, 1'b0);
    in_base = 64'd200; in_index = 64'd1;
    @(posedge clk); @(negedge clk);
    check("R8 stall stable", {3'd0, out_valid, in_ready, out_dest, out_result},
          {3'd0, 1'b1, 1'b0, 5'd10, 64'd102});
    out_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    check("R8 second accepted", {4'd0, out_valid, out_dest, out_result},
          {4'd0, 1'b1, 5'd11, 64'd204});
    @(posedge clk); @(negedge clk);
    check("R8 drained", {73'd0, out_valid}, {73'd0, 1'b0});

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule